// File: doc/BRIEF.md
# Block-Wide Divergence Stack

This block keeps the control-flow state of one whole thread block while its threads take different sides of branches. Each stack level records a program counter, the program counter where the split paths meet again, and a mask with one bit per thread of the block. The top level names the path that runs now. A compaction unit can regroup that path's threads into dense warps.

At a branch every warp that still has live threads on the current path sends one report. The report gives its warp number, its per-lane taken bits and the branch's three addresses. The stack merges these reports and keeps the top unchanged until the last live warp has reported. It then turns the current top into the meeting-point level and stacks the not-taken path with the taken path above it. In that same cycle it emits a one-cycle start pulse for compaction. When the running path reports that its next address equals its meeting point, the level is removed and its threads fall back into the wider level below. Once all branches have closed, the single bottom level again covers the whole block in its original warp layout.

Top module: `bws_reconv_stack`

## Requirements
- R1: A launch request (`init_valid`) empties the stack and loads one level with PC `init_pc`, every mask bit set and no meeting point. It also clears `overflow` and drops any branch still being collected. A launch wins over branch and completion reports in the same cycle.
- R2: After reset the stack is empty: `top_valid`, `top_mask`, `compact_start` and `overflow` are all 0.
- R3: Thread t of the block is mask bit t, and it belongs to warp t / WARP_W, lane t % WARP_W. A branch report's taken bits are ANDed with that warp's bits in the top mask, and the rest of that warp's live bits count as not taken. The first accepted report fixes the target, fall-through and meeting-point addresses. The number of warps still expected is set to the number of warps with at least one live bit in the top mask. Until that number reaches zero the top level is unchanged.
- R4: A branch report is ignored when the stack is empty, when the warp number is not below NUM_WARPS, when the warp has no live bit in the top mask, or when that warp has already reported for the current branch.
- R5: When the last expected warp reports, the top level's PC becomes the meeting point. The not-taken level (fall-through PC) is then pushed, and the taken level (target PC) is pushed above it. Both pushed levels carry the meeting point.
- R6: A path whose merged mask is zero is not pushed, so a visible top mask is never zero.
- R7: When the branch's meeting point equals the meeting point of the current top level, the top level is replaced by the new paths and is not kept as a separate meeting-point level.
- R8: `compact_start` is high for the single cycle after the clock edge that completes a branch without overflow. In that cycle the outputs already show the new top.
- R9: A completion report whose PC equals the top level's meeting point removes the top level. Any other completion report sets the top PC to the reported PC. The bottom level has no meeting point and is never removed.
- R10: Completion reports are ignored while a branch is being collected, and also when a branch report arrives in the same cycle.
- R11: If completing a branch would need more than DEPTH levels, `overflow` is set, the stack is left unchanged, the collected branch is discarded and no pulse is given. `overflow` then stays set until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_valid | input | 1 | Launch the block |
| init_pc | input | PC_W | Start address of the block |
| br_valid | input | 1 | Branch report strobe |
| br_warp | input | WID_W | Reporting warp number |
| br_taken | input | WARP_W | Per-lane taken bits of that warp |
| br_target_pc | input | PC_W | Taken-path address |
| br_fallthru_pc | input | PC_W | Not-taken-path address |
| br_reconv_pc | input | PC_W | Address where both paths meet |
| done_valid | input | 1 | Completion report strobe for the running path |
| done_pc | input | PC_W | Next address of the running path |
| top_valid | output | 1 | Stack holds at least one level |
| top_pc | output | PC_W | PC of the top level |
| top_mask | output | NUM_WARPS*WARP_W | Thread mask of the top level, zero when empty |
| compact_start | output | 1 | One-cycle compaction start pulse |
| overflow | output | 1 | Sticky stack overflow flag |

## Verification
The bench builds the block with three warps of four lanes and a depth of four levels. With these values the twelve-thread split from the usual worked example can be checked bit for bit against hand-computed masks. The two-bit warp number can name a nonexistent fourth warp, and two nested divergent branches are enough to overflow the stack. A sweep of sixteen taken patterns with rotated arrival orders reaches the uniform branches (one path empty) and the fully split branches, and each result is compared with a stack model written from the requirements.

// File: rtl/bws_pkg.sv
package bws_pkg;

    // Collection phase of the stack controller.
    typedef enum logic {
        PH_RUN    = 1'b0,
        PH_GATHER = 1'b1
    } bws_phase_e;

endpackage

// File: rtl/bws_warp_select.sv
// Picks one warp's slice out of a block-wide mask and gives a one-hot warp select.
module bws_warp_select #(
    parameter int NUM_WARPS = 4,
    parameter int WARP_W    = 8,
    parameter int WID_W     = 2,
    localparam int THREADS  = NUM_WARPS * WARP_W
) (
    input  logic [THREADS-1:0]   mask,
    input  logic [WID_W-1:0]     warp,
    output logic [NUM_WARPS-1:0] sel_oh,
    output logic [WARP_W-1:0]    bits
);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_sel
        assign sel_oh[w] = (warp == WID_W'(w));
    end

    always_comb begin
        bits = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (sel_oh[w]) begin
                bits = bits | mask[w*WARP_W +: WARP_W];
            end
        end
    end

endmodule

// File: rtl/bws_warp_scatter.sv
// Places one warp's lane bits at that warp's position in a block-wide mask.
module bws_warp_scatter #(
    parameter int NUM_WARPS = 4,
    parameter int WARP_W    = 8,
    localparam int THREADS  = NUM_WARPS * WARP_W
) (
    input  logic [NUM_WARPS-1:0] sel_oh,
    input  logic [WARP_W-1:0]    bits,
    output logic [THREADS-1:0]   wide
);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_place
        assign wide[w*WARP_W +: WARP_W] = sel_oh[w] ? bits : '0;
    end

endmodule

// File: rtl/bws_warp_census.sv
// Counts the warps that hold at least one live thread in a block-wide mask.
module bws_warp_census #(
    parameter int NUM_WARPS = 4,
    parameter int WARP_W    = 8,
    parameter int CNT_W     = 3,
    localparam int THREADS  = NUM_WARPS * WARP_W
) (
    input  logic [THREADS-1:0] mask,
    output logic [CNT_W-1:0]   live_cnt
);

    logic [NUM_WARPS-1:0] live;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_live
        assign live[w] = |mask[w*WARP_W +: WARP_W];
    end

    always_comb begin
        live_cnt = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            live_cnt = live_cnt + CNT_W'(live[w]);
        end
    end

endmodule

// File: rtl/bws_reconv_stack.sv
module bws_reconv_stack #(
    parameter int NUM_WARPS = 4,
    parameter int WARP_W    = 8,
    parameter int PC_W      = 16,
    parameter int DEPTH     = 8,
    localparam int THREADS  = NUM_WARPS * WARP_W,
    localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_valid,
    input  logic [PC_W-1:0]    init_pc,
    input  logic               br_valid,
    input  logic [WID_W-1:0]   br_warp,
    input  logic [WARP_W-1:0]  br_taken,
    input  logic [PC_W-1:0]    br_target_pc,
    input  logic [PC_W-1:0]    br_fallthru_pc,
    input  logic [PC_W-1:0]    br_reconv_pc,
    input  logic               done_valid,
    input  logic [PC_W-1:0]    done_pc,
    output logic               top_valid,
    output logic [PC_W-1:0]    top_pc,
    output logic [THREADS-1:0] top_mask,
    output logic               compact_start,
    output logic               overflow
);
    import bws_pkg::*;

    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int CNT_W = $clog2(NUM_WARPS + 1);

    typedef struct packed {
        logic [PC_W-1:0]    pc;
        logic [PC_W-1:0]    rpc;
        logic               rpc_ok;
        logic [THREADS-1:0] mask;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0]   stk;
        logic [SP_W-1:0]      sp;
        bws_phase_e           ph;
        logic [NUM_WARPS-1:0] arrived;
        logic [CNT_W-1:0]     left;
        logic [THREADS-1:0]   tk;
        logic [THREADS-1:0]   nt;
        logic [PC_W-1:0]      tgt;
        logic [PC_W-1:0]      fall;
        logic [PC_W-1:0]      rpc;
        logic                 pulse;
        logic                 ovf;
    } state_t;

    state_t st_d, st_q;

    // Top level view
    entry_t top_e;
    always_comb begin
        top_e = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.sp == SP_W'(i + 1)) begin
                top_e = st_q.stk[i];
            end
        end
    end

    // Per-warp decode of the incoming branch report
    logic [NUM_WARPS-1:0] sel_oh;
    logic [WARP_W-1:0]    act_bits;
    logic [CNT_W-1:0]     live_cnt;
    logic [THREADS-1:0]   tk_add;
    logic [THREADS-1:0]   nt_add;

    bws_warp_select #(.NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W), .WID_W(WID_W)) i_select (
        .mask   (top_e.mask),
        .warp   (br_warp),
        .sel_oh (sel_oh),
        .bits   (act_bits)
    );

    bws_warp_census #(.NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W), .CNT_W(CNT_W)) i_census (
        .mask     (top_e.mask),
        .live_cnt (live_cnt)
    );

    bws_warp_scatter #(.NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W)) i_tk_scatter (
        .sel_oh (sel_oh),
        .bits   (br_taken & act_bits),
        .wide   (tk_add)
    );

    bws_warp_scatter #(.NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W)) i_nt_scatter (
        .sel_oh (sel_oh),
        .bits   (~br_taken & act_bits),
        .wide   (nt_add)
    );

    // Next-state working values
    logic               stack_live;
    logic               gathering;
    logic               accept;
    logic [CNT_W-1:0]   left_now;
    logic [CNT_W-1:0]   left_after;
    logic [THREADS-1:0] tk_new;
    logic [THREADS-1:0] nt_new;
    logic [PC_W-1:0]    use_tgt;
    logic [PC_W-1:0]    use_fall;
    logic [PC_W-1:0]    use_rpc;
    logic               tk_any;
    logic               nt_any;
    logic               merge;
    logic [SP_W:0]      base_w;
    logic [SP_W:0]      tk_idx;
    logic [SP_W:0]      end_w;
    logic               pop_hit;

    always_comb begin
        stack_live = (st_q.sp != '0);
        gathering  = (st_q.ph == PH_GATHER);
        accept     = br_valid && stack_live && (|act_bits) && !(gathering && |(st_q.arrived & sel_oh));
        left_now   = gathering ? st_q.left : live_cnt;
        left_after = left_now - 1'b1;
        tk_new     = (gathering ? st_q.tk : '0) | tk_add;
        nt_new     = (gathering ? st_q.nt : '0) | nt_add;
        use_tgt    = gathering ? st_q.tgt  : br_target_pc;
        use_fall   = gathering ? st_q.fall : br_fallthru_pc;
        use_rpc    = gathering ? st_q.rpc  : br_reconv_pc;
        tk_any     = |tk_new;
        nt_any     = |nt_new;
        merge      = top_e.rpc_ok && (top_e.rpc == use_rpc);
        base_w     = merge ? ({1'b0, st_q.sp} - 1'b1) : {1'b0, st_q.sp};
        tk_idx     = base_w + (SP_W+1)'(nt_any);
        end_w      = tk_idx + (SP_W+1)'(tk_any);
        pop_hit    = top_e.rpc_ok && (done_pc == top_e.rpc);
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;

        if (init_valid) begin
            st_d.stk         = '0;
            st_d.stk[0].pc   = init_pc;
            st_d.stk[0].mask = '1;
            st_d.sp          = SP_W'(1);
            st_d.ph          = PH_RUN;
            st_d.arrived     = '0;
            st_d.left        = '0;
            st_d.tk          = '0;
            st_d.nt          = '0;
            st_d.ovf         = 1'b0;
        end else if (accept) begin
            if (left_after != '0) begin
                st_d.ph      = PH_GATHER;
                st_d.arrived = st_q.arrived | sel_oh;
                st_d.left    = left_after;
                st_d.tk      = tk_new;
                st_d.nt      = nt_new;
                st_d.tgt     = use_tgt;
                st_d.fall    = use_fall;
                st_d.rpc     = use_rpc;
            end else begin
                st_d.ph      = PH_RUN;
                st_d.arrived = '0;
                st_d.left    = '0;
                st_d.tk      = '0;
                st_d.nt      = '0;
                if (end_w > (SP_W+1)'(DEPTH)) begin
                    st_d.ovf = 1'b1;
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (!merge && st_q.sp == SP_W'(i + 1)) begin
                            st_d.stk[i].pc = use_rpc;
                        end
                        if (nt_any && base_w == (SP_W+1)'(i)) begin
                            st_d.stk[i].pc     = use_fall;
                            st_d.stk[i].rpc    = use_rpc;
                            st_d.stk[i].rpc_ok = 1'b1;
                            st_d.stk[i].mask   = nt_new;
                        end
                        if (tk_any && tk_idx == (SP_W+1)'(i)) begin
                            st_d.stk[i].pc     = use_tgt;
                            st_d.stk[i].rpc    = use_rpc;
                            st_d.stk[i].rpc_ok = 1'b1;
                            st_d.stk[i].mask   = tk_new;
                        end
                    end
                    st_d.sp    = end_w[SP_W-1:0];
                    st_d.pulse = 1'b1;
                end
            end
        end else if (done_valid && !br_valid && stack_live && !gathering) begin
            if (pop_hit) begin
                st_d.sp = st_q.sp - 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (st_q.sp == SP_W'(i + 1)) begin
                        st_d.stk[i].pc = done_pc;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top_valid     = (st_q.sp != '0);
    assign top_pc        = top_e.pc;
    assign top_mask      = top_e.mask;
    assign compact_start = st_q.pulse;
    assign overflow      = st_q.ovf;

endmodule

// File: rtl/bws_reconv_stack_chk.sv
module bws_reconv_stack_chk #(
    parameter int PC_W    = 16,
    parameter int THREADS = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               init_valid,
    input logic               br_valid,
    input logic               done_valid,
    input logic               top_valid,
    input logic [PC_W-1:0]    top_pc,
    input logic [THREADS-1:0] top_mask,
    input logic               compact_start,
    input logic               overflow
);

    AST_LAUNCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |=> top_valid && top_mask == {THREADS{1'b1}} && !overflow && !compact_start); // R1

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !top_valid |-> top_mask == '0 && !compact_start); // R2

    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> top_mask != '0); // R6

    AST_PULSE_FROM_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        compact_start |-> $past(br_valid) && top_valid); // R8

    AST_BOTTOM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid && !init_valid |=> top_valid); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !init_valid && !br_valid && !done_valid |=> $stable(top_pc) && $stable(top_mask) && $stable(top_valid)); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !init_valid |=> overflow); // R11

    AST_OVF_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> !compact_start); // R11

endmodule

bind bws_reconv_stack bws_reconv_stack_chk #(.PC_W(PC_W), .THREADS(THREADS)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_valid    (init_valid),
    .br_valid      (br_valid),
    .done_valid    (done_valid),
    .top_valid     (top_valid),
    .top_pc        (top_pc),
    .top_mask      (top_mask),
    .compact_start (compact_start),
    .overflow      (overflow)
);

// File: tb/test_bws_reconv_stack.sv
module test_bws_reconv_stack;

    localparam int NW  = 3;
    localparam int WW  = 4;
    localparam int PCW = 8;
    localparam int DEP = 4;
    localparam int THR = NW * WW;
    localparam int WIDW = 2;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic            rst_n;
    logic            init_valid;
    logic [PCW-1:0]  init_pc;
    logic            br_valid;
    logic [WIDW-1:0] br_warp;
    logic [WW-1:0]   br_taken;
    logic [PCW-1:0]  br_target_pc, br_fallthru_pc, br_reconv_pc;
    logic            done_valid;
    logic [PCW-1:0]  done_pc;
    logic            top_valid;
    logic [PCW-1:0]  top_pc;
    logic [THR-1:0]  top_mask;
    logic            compact_start;
    logic            overflow;

    bws_reconv_stack #(.NUM_WARPS(NW), .WARP_W(WW), .PC_W(PCW), .DEPTH(DEP)) i_bws_reconv_stack (
        .clk(clk), .rst_n(rst_n),
        .init_valid(init_valid), .init_pc(init_pc),
        .br_valid(br_valid), .br_warp(br_warp), .br_taken(br_taken),
        .br_target_pc(br_target_pc), .br_fallthru_pc(br_fallthru_pc), .br_reconv_pc(br_reconv_pc),
        .done_valid(done_valid), .done_pc(done_pc),
        .top_valid(top_valid), .top_pc(top_pc), .top_mask(top_mask),
        .compact_start(compact_start), .overflow(overflow)
    );

    int checks = 0;
    int errors = 0;

    // Reference stack built from the requirements
    logic [PCW-1:0] mpc  [DEP];
    logic [PCW-1:0] mrpc [DEP];
    logic           mrok [DEP];
    logic [THR-1:0] mmask[DEP];
    int             msp = 0;
    bit             mgath = 0;
    logic [NW-1:0]  marr = '0;
    int             mleft = 0;
    logic [THR-1:0] mtk, mnt;
    logic [PCW-1:0] mtgt, mfall, mrb;
    bit             movf = 0;
    bit             mpulse = 0;

    function automatic logic [WW-1:0] warp_bits(logic [THR-1:0] m, int w);
        logic [THR-1:0] s;
        s = m >> (w * WW);
        return s[WW-1:0];
    endfunction

    task automatic m_init(logic [PCW-1:0] pc);
        msp = 1; mpc[0] = pc; mrpc[0] = '0; mrok[0] = 1'b0; mmask[0] = '1;
        mgath = 0; marr = '0; movf = 0; mpulse = 0;
    endtask

    task automatic m_branch(int w, logic [WW-1:0] tk, logic [PCW-1:0] tgt,
                            logic [PCW-1:0] fall, logic [PCW-1:0] rpc);
        logic [WW-1:0] act;
        bit merge;
        int base, idx, live;
        mpulse = 0;
        if (msp == 0 || w >= NW) return;
        act = warp_bits(mmask[msp-1], w);
        if (act == '0) return;
        if (mgath && marr[w]) return;
        if (!mgath) begin
            live = 0;
            for (int v = 0; v < NW; v++) if (warp_bits(mmask[msp-1], v) != '0) live++;
            mleft = live; mtk = '0; mnt = '0; mtgt = tgt; mfall = fall; mrb = rpc;
            marr = '0; mgath = 1;
        end
        marr[w] = 1'b1;
        mtk = mtk | (THR'(tk & act) << (w * WW));
        mnt = mnt | (THR'(~tk & act) << (w * WW));
        mleft--;
        if (mleft == 0) begin
            mgath = 0; marr = '0;
            merge = mrok[msp-1] && (mrpc[msp-1] == mrb);
            base = merge ? msp - 1 : msp;
            if (base + int'(mtk != '0) + int'(mnt != '0) > DEP) begin
                movf = 1;
            end else begin
                if (!merge) mpc[msp-1] = mrb;
                idx = base;
                if (mnt != '0) begin
                    mpc[idx] = mfall; mrpc[idx] = mrb; mrok[idx] = 1'b1; mmask[idx] = mnt; idx++;
                end
                if (mtk != '0) begin
                    mpc[idx] = mtgt; mrpc[idx] = mrb; mrok[idx] = 1'b1; mmask[idx] = mtk; idx++;
                end
                msp = idx;
                mpulse = 1;
            end
        end
    endtask

    task automatic m_done(logic [PCW-1:0] pc);
        mpulse = 0;
        if (msp == 0 || mgath) return;
        if (mrok[msp-1] && pc == mrpc[msp-1]) msp--;
        else mpc[msp-1] = pc;
    endtask

    task automatic compare(string tag);
        logic           ev;
        logic [PCW-1:0] epc;
        logic [THR-1:0] em;
        ev  = (msp != 0);
        epc = ev ? mpc[msp-1] : '0;
        em  = ev ? mmask[msp-1] : '0;
        checks++;
        if (top_valid !== ev || (ev && top_pc !== epc) || top_mask !== em ||
            compact_start !== mpulse || overflow !== movf) begin
            errors++;
            $display("FAIL %s: got v=%0b pc=%h mask=%h cs=%0b ovf=%0b expected v=%0b pc=%h mask=%h cs=%0b ovf=%0b",
                     tag, top_valid, top_pc, top_mask, compact_start, overflow,
                     ev, epc, em, mpulse, movf);
        end
    endtask

    task automatic check_direct(string tag, logic [PCW-1:0] epc, logic [THR-1:0] em);
        checks++;
        if (top_pc !== epc || top_mask !== em) begin
            errors++;
            $display("FAIL %s: got pc=%h mask=%h expected pc=%h mask=%h", tag, top_pc, top_mask, epc, em);
        end
    endtask

    task automatic clear_inputs();
        init_valid = 0; br_valid = 0; done_valid = 0;
    endtask

    task automatic do_init(logic [PCW-1:0] pc, string tag);
        @(negedge clk);
        init_valid = 1; init_pc = pc;
        @(negedge clk);
        clear_inputs();
        m_init(pc);
        compare(tag);
    endtask

    task automatic do_branch(int w, logic [WW-1:0] tk, logic [PCW-1:0] tgt,
                             logic [PCW-1:0] fall, logic [PCW-1:0] rpc, string tag);
        @(negedge clk);
        br_valid = 1; br_warp = WIDW'(w); br_taken = tk;
        br_target_pc = tgt; br_fallthru_pc = fall; br_reconv_pc = rpc;
        @(negedge clk);
        clear_inputs();
        m_branch(w, tk, tgt, fall, rpc);
        compare(tag);
    endtask

    task automatic do_done(logic [PCW-1:0] pc, string tag);
        @(negedge clk);
        done_valid = 1; done_pc = pc;
        @(negedge clk);
        clear_inputs();
        m_done(pc);
        compare(tag);
    endtask

    task automatic do_both(int w, logic [WW-1:0] tk, logic [PCW-1:0] tgt,
                           logic [PCW-1:0] fall, logic [PCW-1:0] rpc,
                           logic [PCW-1:0] dpc, string tag);
        @(negedge clk);
        br_valid = 1; br_warp = WIDW'(w); br_taken = tk;
        br_target_pc = tgt; br_fallthru_pc = fall; br_reconv_pc = rpc;
        done_valid = 1; done_pc = dpc;
        @(negedge clk);
        clear_inputs();
        m_branch(w, tk, tgt, fall, rpc);
        compare(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got run still active expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        rst_n = 0;
        clear_inputs();
        init_pc = '0; br_warp = '0; br_taken = '0;
        br_target_pc = '0; br_fallthru_pc = '0; br_reconv_pc = '0; done_pc = '0;
        repeat (3) @(negedge clk);
        compare("R2 reset state");
        rst_n = 1;

        // Branch on an empty stack
        do_branch(0, 4'hF, 8'h01, 8'h02, 8'h03, "R4 empty stack");

        // Twelve-thread split: threads 1,2,5,7,8,11,12 (1-based) take the branch
        do_init(8'h0B, "R1 launch");
        do_branch(2, 4'b1100, 8'h0C, 8'h0D, 8'h0E, "R3 first arrival holds top");
        do_done(8'h77, "R10 done while collecting");
        do_branch(0, 4'b0011, 8'h0C, 8'h0D, 8'h0E, "R3 second arrival holds top");
        do_branch(0, 4'b1111, 8'h0C, 8'h0D, 8'h0E, "R4 duplicate warp");
        do_branch(3, 4'b1111, 8'h0C, 8'h0D, 8'h0E, "R4 warp out of range");
        do_branch(1, 4'b1101, 8'h0C, 8'h0D, 8'h0E, "R5 last arrival pushes paths");
        check_direct("R5 taken path on top", 8'h0C, 12'hCD3);
        @(negedge clk); mpulse = 0; compare("R8 pulse lasts one cycle");
        do_done(8'h0E, "R9 pop at meeting point");
        check_direct("R5 not-taken path below", 8'h0D, 12'h32C);
        do_done(8'h0F, "R9 pc advance");
        do_done(8'h0E, "R9 pop to meeting level");
        check_direct("R5 meeting level restored", 8'h0E, 12'hFFF);
        do_done(8'h0E, "R9 bottom level kept");

        // Path of one warp only; other warps' reports are ignored
        do_init(8'h30, "R1 relaunch");
        do_branch(0, 4'hF, 8'h31, 8'h32, 8'h3F, "R3 collect");
        do_branch(1, 4'h0, 8'h31, 8'h32, 8'h3F, "R3 collect");
        do_branch(2, 4'h0, 8'h31, 8'h32, 8'h3F, "R5 split by warp");
        do_branch(1, 4'hF, 8'h41, 8'h42, 8'h4F, "R4 warp without live threads");
        do_both(0, 4'b0110, 8'h41, 8'h42, 8'h4F, 8'h4F, "R10 branch wins over done");
        do_done(8'h4F, "R9 nested pop");

        // Uniform branch: the empty path is not pushed
        do_init(8'h40, "R1 relaunch");
        for (int w = 0; w < NW; w++) do_branch(w, 4'hF, 8'h41, 8'h42, 8'h4F, "R6 uniform taken");
        do_done(8'h4F, "R6 single path pops");
        for (int w = 0; w < NW; w++) do_branch(w, 4'h0, 8'h51, 8'h52, 8'h5E, "R6 uniform not taken");
        check_direct("R6 only fall-through pushed", 8'h52, 12'hFFF);

        // Shared meeting point replaces the top level
        do_init(8'h50, "R1 relaunch");
        for (int w = 0; w < NW; w++) do_branch(w, 4'b0101, 8'h51, 8'h52, 8'h5F, "R5 outer split");
        for (int w = 0; w < NW; w++) do_branch(w, 4'b0100, 8'h53, 8'h54, 8'h5F, "R7 nested same meeting point");
        check_direct("R7 nested taken", 8'h53, 12'h444);
        do_done(8'h5F, "R7 pop nested taken");
        check_direct("R7 nested not-taken", 8'h54, 12'h111);
        do_done(8'h5F, "R7 pop nested not-taken");
        check_direct("R7 outer not-taken next", 8'h52, 12'hAAA);
        do_done(8'h5F, "R7 pop outer");

        // Overflow
        do_init(8'h60, "R1 relaunch");
        for (int w = 0; w < NW; w++) do_branch(w, 4'b0011, 8'h61, 8'h62, 8'h6F, "R5 first level");
        for (int w = 0; w < NW; w++) do_branch(w, 4'b0001, 8'h63, 8'h64, 8'h6E, "R11 push beyond depth");
        do_done(8'h65, "R11 overflow sticky");
        do_init(8'h70, "R1 launch clears overflow");

        // Sweep of taken patterns and arrival orders
        for (int k = 0; k < 16; k++) begin
            do_init(8'h80, "R1 sweep launch");
            for (int j = 0; j < NW; j++) begin
                int w;
                w = (j + k) % NW;
                do_branch(w, WW'(k * (w + 1) + w * 7), 8'h81, 8'h82, 8'h8F, "R5 sweep branch");
            end
            if (msp > 1) do_done(8'h85, "R9 sweep advance");
            while (msp > 1) do_done(8'h8F, "R9 sweep pop");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule